// File: doc/BRIEF.md
# Wake-up Pattern Matcher

This block watches the bytes of each received frame and decides, at the frame's last byte, which of eight programmed wake-up signatures the frame carries. Each signature has three parts: a 64-bit byte-select mask over the first 64 bytes of the frame, an expected CRC, and a reference byte. Each of the eight pattern lanes runs its own CRC over only the bytes its mask selects. At the end of the frame the lane compares its CRC with the stored value. It also compares the last selected byte with the reference byte.

Firmware loads each pattern through a simple write port, one pattern per write. One global setting picks the compare width, either 8-bit or 16-bit. The result comes out as a one-cycle hit vector after every frame. If at least one pattern hit and wake-up is enabled, a wake event pulse comes out with it.

Top module: `wk_match`

## Requirements
- R1: While `rst_n` is low, every mask, expected CRC and reference byte is cleared. A cycle with `cfg_we` high loads `cfg_mask`, `cfg_crc` and `cfg_tail` into the pattern numbered `cfg_sel` (0 to 7) and leaves the other seven patterns unchanged.
- R2: Byte k of a frame (k counted from 0 at the first byte after the previous `rx_last`) enters pattern p's CRC only if bit k of p's mask is set. Bytes at index 64 and above never enter any CRC.
- R3: The CRC is CRC-16 with polynomial x^16+x^15+x^2+1 in reflected form (0xA001), initial value 0xFFFF, and each byte shifted in least significant bit first. It restarts at 0xFFFF for every frame.
- R4: With `cfg_wide` = 1 all 16 CRC bits must equal the stored value. With `cfg_wide` = 0 only the low 8 bits are compared.
- R5: A pattern hits only if the frame byte at its highest selected index equals its stored reference byte.
- R6: A pattern whose mask is all zero never hits.
- R7: A frame whose byte count is not greater than a pattern's highest selected index does not hit that pattern.
- R8: `hit_valid` is high for exactly the one cycle after the clock edge that takes a byte with `rx_last` = 1. In that cycle, `hit_vec` bit p is 1 when pattern p matched. `hit_vec` is zero in every other cycle.
- R9: If `wake_en` is low when the last byte is taken, `hit_vec` is all zero and `wake_evt` stays low. `wake_evt` is high exactly when `hit_valid` is high and `hit_vec` is nonzero.
- R10: Several patterns can hit the same frame together, and each one sets its own bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load one pattern this cycle |
| cfg_sel | input | 3 | Pattern number to load |
| cfg_mask | input | 64 | Byte-select mask, bit k selects frame byte k |
| cfg_crc | input | 16 | Expected CRC |
| cfg_tail | input | 8 | Reference value of the last selected byte |
| cfg_wide | input | 1 | 1: compare 16 CRC bits, 0: compare low 8 bits |
| wake_en | input | 1 | Enables hits and the wake event |
| rx_valid | input | 1 | A frame byte is present |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | This byte ends the frame |
| hit_valid | output | 1 | One-cycle result strobe |
| hit_vec | output | 8 | Per-pattern hit flags |
| wake_evt | output | 1 | Wake event pulse |

## Verification
The only state that lasts across frames is the stored pattern set. A fault there shows up at the first later frame that uses the affected pattern, as a wrong bit in `hit_vec`. A fault in the per-frame CRC or byte-position state shows up as a wrong hit flag one cycle after that frame's last byte. The same fault can also surface one frame later if the state fails to restart. For these reasons the bench compares the result strobe, the vector and the wake pulse against a behavioural model on every clock. It runs back-to-back frames, frames shorter than a mask's reach, and frames longer than the 64-byte window.

// File: rtl/wk_pkg.sv
package wk_pkg;

    localparam int CRC_W = 16;
    localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 16'hA001;

    // One byte through the reflected CRC-16, least significant bit first.
    function automatic logic [CRC_W-1:0] crc16_byte(input logic [CRC_W-1:0] c,
                                                    input logic [7:0] b);
        logic [CRC_W-1:0] r;
        r = c ^ {8'h00, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/wk_pos.sv
module wk_pos #(
    parameter int WIN  = 64,
    parameter int POSW = $clog2(WIN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            byte_vld,
    input  logic            frame_end,
    output logic [POSW-1:0] pos
);
    typedef struct packed {
        logic [POSW-1:0] idx;
    } pos_t;

    pos_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (frame_end) begin
            s_d.idx = '0;
        end else if (byte_vld && (s_q.idx < POSW'(WIN))) begin
            s_d.idx = s_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pos = s_q.idx;

    // R2: the position never passes the one-past-window marker
    a_r2_pos_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.idx <= POSW'(WIN));

endmodule

// File: rtl/wk_lane.sv
module wk_lane #(
    parameter int WIN  = 64,
    parameter int POSW = $clog2(WIN + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [WIN-1:0]           wr_mask,
    input  logic [wk_pkg::CRC_W-1:0] wr_crc,
    input  logic [7:0]               wr_tail,
    input  logic                     byte_vld,
    input  logic [7:0]               byte_dat,
    input  logic [POSW-1:0]          byte_pos,
    input  logic                     frame_end,
    input  logic                     wide,
    output logic                     hit
);
    localparam int IDXW = $clog2(WIN);
    localparam int CW   = wk_pkg::CRC_W;

    typedef struct packed {
        logic [WIN-1:0] mask;
        logic [CW-1:0]  exp_crc;
        logic [7:0]     tail_ref;
        logic [CW-1:0]  crc;
        logic [7:0]     tail_seen;
    } lane_t;

    lane_t s_d, s_q;

    logic            sel;
    logic [CW-1:0]   crc_now;
    logic [7:0]      tail_now;
    logic [POSW-1:0] nxt_pos;
    logic            covered;
    logic            crc_ok;

    always_comb begin
        s_d      = s_q;
        sel      = byte_vld && (byte_pos < POSW'(WIN)) && s_q.mask[byte_pos[IDXW-1:0]];
        crc_now  = sel ? wk_pkg::crc16_byte(s_q.crc, byte_dat) : s_q.crc;
        tail_now = sel ? byte_dat : s_q.tail_seen;
        nxt_pos  = byte_pos + 1'b1;
        // frame length reaches every selected byte
        covered  = (byte_pos >= POSW'(WIN - 1)) || ((s_q.mask >> nxt_pos) == '0);
        crc_ok   = wide ? (crc_now == s_q.exp_crc) : (crc_now[7:0] == s_q.exp_crc[7:0]);
        hit      = frame_end && (s_q.mask != '0) && covered && crc_ok &&
                   (tail_now == s_q.tail_ref);
        if (frame_end) begin
            s_d.crc       = wk_pkg::CRC_SEED;
            s_d.tail_seen = '0;
        end else begin
            s_d.crc       = crc_now;
            s_d.tail_seen = tail_now;
        end
        if (wr_en) begin
            s_d.mask     = wr_mask;
            s_d.exp_crc  = wr_crc;
            s_d.tail_ref = wr_tail;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.crc       <= wk_pkg::CRC_SEED;
        end else begin
            s_q <= s_d;
        end
    end

    // R6: an empty mask keeps the lane silent
    a_r6_empty_mask_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mask == '0) |-> !hit);

    // R3: the CRC restarts from the seed after each frame
    a_r3_crc_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frame_end) |-> (s_q.crc == wk_pkg::CRC_SEED));

endmodule

// File: rtl/wk_match.sv
module wk_match #(
    parameter int NPAT = 8,
    parameter int WIN  = 64,
    localparam int SELW = $clog2(NPAT),
    localparam int POSW = $clog2(WIN + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [SELW-1:0]          cfg_sel,
    input  logic [WIN-1:0]           cfg_mask,
    input  logic [wk_pkg::CRC_W-1:0] cfg_crc,
    input  logic [7:0]               cfg_tail,
    input  logic                     cfg_wide,
    input  logic                     wake_en,
    input  logic                     rx_valid,
    input  logic [7:0]               rx_data,
    input  logic                     rx_last,
    output logic                     hit_valid,
    output logic [NPAT-1:0]          hit_vec,
    output logic                     wake_evt
);
    typedef struct packed {
        logic            valid;
        logic [NPAT-1:0] vec;
        logic            wake;
    } res_t;

    res_t            r_d, r_q;
    logic            frame_end;
    logic [POSW-1:0] pos;
    logic [NPAT-1:0] lane_hit;

    assign frame_end = rx_valid && rx_last;

    wk_pos #(.WIN(WIN), .POSW(POSW)) u_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (rx_valid),
        .frame_end (frame_end),
        .pos       (pos)
    );

    for (genvar g = 0; g < NPAT; g++) begin : g_lane
        wk_lane #(.WIN(WIN), .POSW(POSW)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (cfg_we && (cfg_sel == SELW'(g))),
            .wr_mask   (cfg_mask),
            .wr_crc    (cfg_crc),
            .wr_tail   (cfg_tail),
            .byte_vld  (rx_valid),
            .byte_dat  (rx_data),
            .byte_pos  (pos),
            .frame_end (frame_end),
            .wide      (cfg_wide),
            .hit       (lane_hit[g])
        );
    end

    always_comb begin
        r_d       = '0;
        r_d.valid = frame_end;
        r_d.vec   = wake_en ? lane_hit : '0;
        r_d.wake  = frame_end && wake_en && (lane_hit != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign hit_valid = r_q.valid;
    assign hit_vec   = r_q.vec;
    assign wake_evt  = r_q.wake;

    // R9: a wake event needs the enable at the last byte
    a_r9_wake_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |-> $past(wake_en));

    // R8: flags only appear with the strobe
    a_r8_flags_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec != '0) |-> hit_valid);

    // R8: the strobe follows a last byte
    a_r8_strobe_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> $past(rx_valid && rx_last));

endmodule

// File: tb/wk_match_bench.sv
`timescale 1ns/1ps
module wk_match_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_sel;
    logic [63:0] cfg_mask;
    logic [15:0] cfg_crc;
    logic [7:0]  cfg_tail;
    logic        cfg_wide;
    logic        wake_en;
    logic        rx_valid;
    logic [7:0]  rx_data;
    logic        rx_last;
    logic        hit_valid;
    logic [7:0]  hit_vec;
    logic        wake_evt;

    always #4 clk = ~clk;

    wk_match u_wk_match (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_mask(cfg_mask), .cfg_crc(cfg_crc), .cfg_tail(cfg_tail),
        .cfg_wide(cfg_wide), .wake_en(wake_en), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_last(rx_last), .hit_valid(hit_valid),
        .hit_vec(hit_vec), .wake_evt(wake_evt)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [63:0] m_mask [8];
    logic [15:0] m_crc  [8];
    logic [7:0]  m_tail [8];
    logic [7:0]  frm [$];

    logic       exp_valid = 1'b0;
    logic [7:0] exp_vec   = 8'h00;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bit-serial reference CRC
    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
        for (int k = 0; k < 8; k++) begin
            logic fb;
            fb = c[0] ^ b[k];
            c  = c >> 1;
            if (fb) c = c ^ 16'hA001;
        end
        return c;
    endfunction

    function automatic logic [23:0] signature(input logic [63:0] m);
        logic [15:0] c;
        logic [7:0]  t;
        c = 16'hFFFF;
        t = 8'h00;
        for (int k = 0; k < 64 && k < frm.size(); k++) begin
            if (m[k]) begin
                c = ref_crc(c, frm[k]);
                t = frm[k];
            end
        end
        return {t, c};
    endfunction

    function automatic logic [7:0] model_hits(input logic en, input logic wide);
        logic [7:0] res;
        res = 8'h00;
        for (int p = 0; p < 8; p++) begin
            int hi;
            logic [23:0] s;
            hi = -1;
            for (int k = 0; k < 64; k++) if (m_mask[p][k]) hi = k;
            if (hi >= 0 && frm.size() > hi) begin
                s = signature(m_mask[p]);
                if ((wide ? (s[15:0] == m_crc[p]) : (s[7:0] == m_crc[p][7:0])) &&
                    s[23:16] == m_tail[p])
                    res[p] = 1'b1;
            end
        end
        return en ? res : 8'h00;
    endfunction

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            check("R8 strobe", {31'd0, hit_valid}, {31'd0, exp_valid});
            check("R8 R9 vector", {24'd0, hit_vec}, {24'd0, exp_valid ? exp_vec : 8'h00});
            check("R9 wake", {31'd0, wake_evt}, {31'd0, exp_valid && (exp_vec != 8'h00)});
            exp_valid = 1'b0;
        end
    end

    task automatic write_pat(input int p, input logic [63:0] m,
                             input logic [15:0] cflip, input logic [7:0] tflip);
        logic [23:0] s;
        s = signature(m);
        cfg_we = 1'b1; cfg_sel = 3'(p); cfg_mask = m;
        cfg_crc = s[15:0] ^ cflip; cfg_tail = s[23:16] ^ tflip;
        m_mask[p] = m; m_crc[p] = s[15:0] ^ cflip; m_tail[p] = s[23:16] ^ tflip;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic mk(input int n, input int seed);
        frm.delete();
        for (int i = 0; i < n; i++) frm.push_back(8'((i * 37 + seed * 11 + 5) & 255));
    endtask

    task automatic send(input string tag, input logic en, input logic [7:0] moi,
                        input logic [7:0] want);
        logic [7:0] mdl;
        mdl = model_hits(en, cfg_wide);
        wake_en = en;
        for (int i = 0; i < frm.size(); i++) begin
            rx_valid = 1'b1; rx_data = frm[i]; rx_last = (i == frm.size() - 1);
            @(posedge clk); #1;
        end
        rx_valid = 1'b0; rx_last = 1'b0;
        exp_valid = 1'b1; exp_vec = mdl;
        @(negedge clk);
        check(tag, {24'd0, hit_vec & moi}, {24'd0, want});
        @(posedge clk); #1;
    endtask

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < 8; p++) begin m_mask[p] = '0; m_crc[p] = '0; m_tail[p] = '0; end
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_mask = '0; cfg_crc = '0;
        cfg_tail = '0; cfg_wide = 1'b1; wake_en = 1'b0; rx_valid = 1'b0;
        rx_data = '0; rx_last = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 R8 reset outputs", {22'd0, hit_valid, hit_vec, wake_evt}, 32'd0);
        @(posedge clk); #1;

        // R1 R6: cleared patterns never hit
        mk(10, 0);
        send("R6 cleared patterns", 1'b1, 8'hFF, 8'h00);

        // R3 basic match on bytes 0..3
        mk(20, 1);
        write_pat(0, 64'h0F, 16'h0, 8'h0);
        send("R3 basic match", 1'b1, 8'h01, 8'h01);
        frm[10] = frm[10] ^ 8'h5A;
        send("R2 unselected byte ignored", 1'b1, 8'h01, 8'h01);
        frm[2] = frm[2] ^ 8'h01;
        send("R2 selected byte counts", 1'b1, 8'h01, 8'h00);

        // R4 compare width
        mk(20, 1);
        write_pat(1, 64'h220, 16'hFF00, 8'h0);
        send("R4 wide rejects high byte", 1'b1, 8'h03, 8'h01);
        cfg_wide = 1'b0;
        send("R4 narrow accepts low byte", 1'b1, 8'h03, 8'h03);
        cfg_wide = 1'b1;

        // R5 reference byte
        write_pat(2, 64'h1080, 16'h0, 8'h01);
        send("R5 wrong reference byte", 1'b1, 8'h04, 8'h00);

        // R10 two patterns together
        write_pat(3, 64'h8001, 16'h0, 8'h0);
        send("R10 two hits", 1'b1, 8'h09, 8'h09);
        send("R3 restart next frame", 1'b1, 8'h09, 8'h09);

        // R9 disabled wake
        send("R9 disabled", 1'b0, 8'hFF, 8'h00);

        // R7 short frame
        mk(41, 2);
        write_pat(4, 64'h0000_0100_0000_0008, 16'h0, 8'h0);
        send("R7 full length hits", 1'b1, 8'h10, 8'h10);
        void'(frm.pop_back());
        send("R7 short frame misses", 1'b1, 8'h10, 8'h00);

        // R2 bytes past the window
        mk(64, 3);
        write_pat(5, 64'h8000_0000_0000_0001, 16'h0, 8'h0);
        for (int i = 0; i < 6; i++) frm.push_back(8'(i * 29 + 3));
        send("R2 bytes past 64 ignored", 1'b1, 8'h20, 8'h20);

        // R8 one-byte frames back to back
        mk(1, 4);
        write_pat(6, 64'h1, 16'h0, 8'h0);
        send("R8 one-byte frame", 1'b1, 8'h40, 8'h40);
        send("R8 one-byte frame again", 1'b1, 8'h40, 8'h40);

        // R1 rewrite one pattern only
        mk(20, 1);
        write_pat(0, 64'h30, 16'h1234, 8'h0);
        send("R1 rewrite isolated", 1'b1, 8'h09, 8'h08);
        send("R6 unwritten pattern", 1'b1, 8'h80, 8'h00);

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule